// File: doc/BRIEF.md
# Ethernet Transmit Deferral Gap Timer

This block sits in front of an Ethernet MAC transmitter and decides when a new frame may start. It counts the quiet time on the medium in nibble times, using a one-cycle strobe that marks each nibble period. When the required gap has passed and a frame is waiting, it raises a transmit-permit level. The permit stays high for the whole frame and drops on the end-of-transmit pulse, which also starts the next gap.

Two gaps are enforced. The first is the back-to-back gap after the station's own frame. Its programmed value is stored short of the real gap by a fixed offset that depends on the duplex mode. The second is the deference gap after another station's carrier drops, which applies only in half duplex. That gap has a sense window: carrier that returns inside the window makes the block start deferring again. Carrier that returns after the window has closed is ignored, and the block transmits at the end of the gap even though a collision will follow. In full duplex, carrier sense plays no part.

Top module: `ipg_defer_timer`

## Requirements
- R1: While reset is held, `tx_ok` is 0. After reset the medium is taken as already idle. A pending request is granted on the first clock edge at which carrier sense is low or full duplex is selected, with no gap counted. In half duplex, carrier that is high after reset withholds the grant.
- R2: `tx_ok` is a level. Once high, it stays high while `tx_end` is low, whatever `tx_req` and `crs` do. It is 0 from the clock edge that samples `tx_end` high.
- R3: In full duplex (`full_dup`=1), after `tx_end` the permit is withheld until `gap_b2b`+3 nibble strobes have been seen. It rises within two clock cycles of that strobe if a request is pending. This also holds for `gap_b2b`=0, which gives 3 strobes.
- R4: In half duplex (`full_dup`=0), the back-to-back gap after `tx_end` is `gap_b2b`+6 nibble strobes. The setting 0x12 gives 24.
- R5: In full duplex, `crs` has no effect. The permit rises after the same number of strobes whether carrier is high or low during the gap.
- R6: In half duplex, the deference gap is `gap_tot` nibble strobes, counted from the first strobe sampled with `crs` low after carrier drops. Strobes sampled while `crs` is high are not counted.
- R7: In half duplex, carrier that is sampled high when fewer than the window's worth of strobes (`gap_win`) have been counted since the drop restarts the deference. The full `gap_tot` strobes are then needed after the next drop.
- R8: In half duplex, carrier that rises once at least `gap_win` (and at least one) strobes have been counted, but before the gap ends, is ignored. The permit rises at `gap_tot` strobes after the original drop while `crs` is still high.
- R9: If `gap_win` is larger than `gap_tot`, the window is taken as equal to `gap_tot`. Carrier seen at any point before the gap ends then restarts the deference.
- R10: The permit never rises without `tx_req`. When the gap has elapsed and no request is pending, `tx_ok` stays 0 and rises within two cycles of `tx_req` going high.
- R11: In half duplex, once the gap has elapsed with no request and no committed late carrier, a new carrier defers the block again. A request made after that carrier needs a fresh `gap_tot` strobes after the carrier drops.
- R12: In half duplex, carrier during a back-to-back gap turns it into a deference gap. After the drop, `gap_tot` strobes are needed in place of the remaining back-to-back count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_stb | input | 1 | One-cycle pulse per nibble time |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | input | 1 | Carrier sense |
| tx_end | input | 1 | One-cycle pulse at the end of the station's own frame |
| tx_req | input | 1 | A frame is waiting to be sent |
| gap_b2b | input | 7 | Back-to-back gap, nibble times minus the duplex offset |
| gap_win | input | 7 | Carrier-sense window of the deference gap, nibble times |
| gap_tot | input | 7 | Total deference gap, nibble times |
| tx_ok | output | 1 | Transmit permit level |

## Verification
A strobe or carrier change sampled at one clock edge moves the counter at that edge. The permit is registered and follows one edge later, so a gap result is due two edges after the deciding strobe. An end-of-transmit pulse clears the permit at the edge that samples it. The bench drives every input on the falling edge and gives each strobe four cycles. After each strobe it waits three rising edges before it reads `tx_ok`. This makes each read fall after the result is due and before the next strobe. At every strobe, the bench compares the permit with whether the expected count has been reached. Each window boundary is tested one strobe on either side.

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
  parameter int GW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nib_stb,
  input  logic          full_dup,
  input  logic          crs,
  input  logic          tx_end,
  input  logic          tx_req,
  input  logic [GW-1:0] gap_b2b,
  input  logic [GW-1:0] gap_win,
  input  logic [GW-1:0] gap_tot,
  output logic          tx_ok
);
  localparam int CW = GW + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] FD_OFS  = CW'(3);
  localparam logic [CW-1:0] HD_OFS  = CW'(6);

  logic [CW-1:0] cnt;
  logic          in_b2b;
  logic          commit;
  logic          tx_ok_q;

  logic [CW-1:0] b2b_tgt, tot, win_eff, target;
  logic          gap_met, late_win, crs_hold, grant;

  assign b2b_tgt  = CW'(gap_b2b) + (full_dup ? FD_OFS : HD_OFS);
  assign tot      = CW'(gap_tot);
  assign win_eff  = (gap_win > gap_tot) ? tot : CW'(gap_win);
  assign target   = in_b2b ? b2b_tgt : tot;
  assign gap_met  = cnt >= target;
  assign late_win = !in_b2b && (cnt != '0) && (cnt >= win_eff) && (cnt < tot);
  assign crs_hold = !full_dup && crs && !(late_win || commit);
  assign grant    = !tx_ok_q && tx_req && gap_met && !crs_hold;
  assign tx_ok    = tx_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CNT_MAX;
      in_b2b  <= 1'b0;
      commit  <= 1'b0;
      tx_ok_q <= 1'b0;
    end else if (tx_end) begin
      tx_ok_q <= 1'b0;
      in_b2b  <= 1'b1;
      cnt     <= '0;
      commit  <= 1'b0;
    end else if (!tx_ok_q) begin
      if (crs_hold) begin
        in_b2b <= 1'b0;
        cnt    <= '0;
        commit <= 1'b0;
      end else begin
        if (nib_stb && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (grant) begin
          tx_ok_q <= 1'b1;
          commit  <= 1'b0;
        end else if (!full_dup && crs && late_win) begin
          commit <= 1'b1;
        end else if (!crs && gap_met) begin
          commit <= 1'b0;
        end
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok && !tx_end |=> tx_ok);

  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> !tx_ok);

  assert_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ok) |-> $past(tx_req));

  assert_fd_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_dup && !tx_end && cnt != '0 |=> cnt != '0);

  assert_early_defer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !full_dup && crs && !tx_ok && !tx_end && !commit && !in_b2b && cnt < win_eff
    |=> cnt == '0);

  assert_late_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !full_dup && !tx_ok && !tx_end && !in_b2b && cnt != '0 && cnt >= win_eff && cnt < tot
    |=> cnt != '0);
endmodule

// File: tb/sim_ipg_defer_timer.sv
module sim_ipg_defer_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nib_stb = 1'b0, full_dup = 1'b0, crs = 1'b1, tx_end = 1'b0, tx_req = 1'b1;
  logic [6:0] gap_b2b = '0, gap_win = '0, gap_tot = '0;
  logic tx_ok;
  int total = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ipg_defer_timer u0 (
    .clk(clk), .rst_n(rst_n), .nib_stb(nib_stb), .full_dup(full_dup), .crs(crs),
    .tx_end(tx_end), .tx_req(tx_req), .gap_b2b(gap_b2b), .gap_win(gap_win),
    .gap_tot(gap_tot), .tx_ok(tx_ok)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx_ok=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe();
    @(negedge clk) nib_stb = 1'b1;
    @(negedge clk) nib_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_pulse();
    @(negedge clk) tx_end = 1'b1;
    @(negedge clk) tx_end = 1'b0;
  endtask

  task automatic carrier_pulse();
    @(negedge clk) crs = 1'b1;
    repeat (2) @(negedge clk);
    crs = 1'b0;
  endtask

  task automatic run_gap(int n, string req);
    for (int k = 1; k <= n; k++) begin
      strobe();
      chk(req, tx_ok, k >= n);
    end
  endtask

  task automatic t_reset_r1();
    repeat (3) @(negedge clk);
    chk("R1", tx_ok, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", tx_ok, 1'b0);
    crs = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", tx_ok, 1'b1);
  endtask

  task automatic t_level_r2();
    tx_req = 1'b0;
    crs = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", tx_ok, 1'b1);
    tx_req = 1'b1;
    crs = 1'b0;
    end_pulse();
    chk("R2", tx_ok, 1'b0);
  endtask

  task automatic t_fd_b2b_r3();
    full_dup = 1'b1;
    gap_b2b = 7'd5;
    end_pulse();
    run_gap(8, "R3");
    gap_b2b = 7'd0;
    end_pulse();
    run_gap(3, "R3");
  endtask

  task automatic t_fd_carrier_r5();
    gap_b2b = 7'd5;
    end_pulse();
    @(negedge clk) crs = 1'b1;
    run_gap(8, "R5");
    crs = 1'b0;
  endtask

  task automatic t_hd_b2b_r4();
    full_dup = 1'b0;
    gap_b2b = 7'h12;
    end_pulse();
    run_gap(24, "R4");
  endtask

  task automatic t_defer_r6();
    gap_tot = 7'd10;
    gap_win = 7'd4;
    end_pulse();
    carrier_pulse();
    run_gap(10, "R6");
  endtask

  task automatic t_early_r7();
    end_pulse();
    carrier_pulse();
    for (int k = 0; k < 3; k++) strobe();
    carrier_pulse();
    run_gap(10, "R7");
  endtask

  task automatic t_late_r8();
    end_pulse();
    carrier_pulse();
    for (int k = 0; k < 4; k++) strobe();
    @(negedge clk) crs = 1'b1;
    for (int k = 5; k <= 10; k++) begin
      strobe();
      chk("R8", tx_ok, k >= 10);
    end
    crs = 1'b0;
  endtask

  task automatic t_clamp_r9();
    gap_win = 7'd20;
    end_pulse();
    carrier_pulse();
    for (int k = 0; k < 9; k++) strobe();
    carrier_pulse();
    run_gap(10, "R9");
    gap_win = 7'd4;
  endtask

  task automatic t_req_r10();
    full_dup = 1'b1;
    gap_b2b = 7'd5;
    tx_req = 1'b0;
    end_pulse();
    for (int k = 0; k < 10; k++) strobe();
    chk("R10", tx_ok, 1'b0);
    @(negedge clk) tx_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", tx_ok, 1'b1);
  endtask

  task automatic t_new_carrier_r11();
    full_dup = 1'b0;
    tx_req = 1'b0;
    end_pulse();
    carrier_pulse();
    for (int k = 0; k < 12; k++) strobe();
    @(negedge clk) crs = 1'b1;
    @(negedge clk) tx_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", tx_ok, 1'b0);
    crs = 1'b0;
    run_gap(10, "R11");
  endtask

  task automatic t_b2b_to_defer_r12();
    gap_b2b = 7'h12;
    end_pulse();
    for (int k = 0; k < 3; k++) strobe();
    carrier_pulse();
    run_gap(10, "R12");
  endtask

  initial begin
    t_reset_r1();
    t_level_r2();
    t_fd_b2b_r3();
    t_fd_carrier_r5();
    t_hd_b2b_r4();
    t_defer_r6();
    t_early_r7();
    t_late_r8();
    t_clamp_r9();
    t_req_r10();
    t_new_carrier_r11();
    t_b2b_to_defer_r12();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete, tx_ok=%b expected completion", tx_ok);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule